// File: doc/BRIEF.md
# Single-Channel Word Mover with Request/Acknowledge Pins

This block copies a programmed number of words from a source address to a destination address over a simple synchronous memory port. Each word takes two memory operations: a read of the source, then a write to the destination. A channel is armed by a one-cycle `start_i` pulse. At that pulse it captures its control fields, its base addresses and its word count. It then runs until the count runs out or an end-of-transfer pin stops it.

The control fields are captured at start. They choose the following, each independently of the others:
- whether the source address steps or stays fixed;
- whether the destination address steps or stays fixed;
- the transfer mode: software driven, or paced by an external request pin;
- the request pin's polarity and whether it is level or edge sensed;
- the acknowledge pin's polarity;
- whether the shared end pin is an abort input or a terminal-count output, and its polarity.

The memory port is a valid/ready request channel. While `mem_valid_o` is high and `mem_ready_i` is low, the block holds the address, the write flag and the write data unchanged. Read data is taken from `mem_rdata_i` in the cycle in which a read is accepted, so the memory must present read data combinationally with ready. Addresses count in words and step by one.

Top module: `dma_xfer_channel`

## Requirements
- R1: Mode code 00 runs from the start pulse with no request. With ready held high, it issues one read and one write per word, so n words finish 2n+1 clock edges after the start edge. Mode code 11 is off: a start with that code leaves the channel idle. A start is ignored while the channel is busy.
- R2: With the source-hold control set to 1, every read uses the source base address. With it set to 0, the source address rises by one after each accepted read.
- R3: With the destination-hold control set to 1, every write uses the destination base address. With it set to 0, the destination address rises by one after each accepted write.
- R4: The remaining count is loaded at start and falls by one per completed write. When it reaches zero, `done_o` rises and `busy_o` falls in the same cycle. A start with count 0 sets `done_o` at once and makes no memory request.
- R5: Mode codes 01 (memory to device) and 10 (device to memory) are paced by the request pin, which passes through a two-flop synchronizer. Request code 00 means active low, level sensed; 01 means active high, level sensed. In level sensing, words keep starting while the request is active, and no word starts while it is inactive. After reset the request code is 00.
- R6: Request code 10 means active low, edge sensed; 11 means active high, edge sensed. In edge sensing, each change into the active level allows exactly one word. A change into the inactive level allows none.
- R7: In the paced modes, the acknowledge pin is active in exactly the cycle in which a word's write is accepted. The acknowledge polarity bit sets the active level: 0 means active low, 1 means active high. At all other times, including software mode, the pin rests at the inactive level.
- R8: End-pin code 10 makes the pin an active-low terminal-count output, and code 11 makes it active high. In these codes `eot_oe_o` is 1, and the pin is active for one cycle, during the accepted write of the final word.
- R9: End-pin code 00 makes the pin an active-low abort input, and code 01 makes it active high. A synchronized active level stops the channel after the word in progress. `done_o` then rises and the remaining count stays readable.
- R10: While a memory request waits for `mem_ready_i`, the valid, write, address and write-data outputs stay unchanged.
- R11: After reset the channel is idle, with no memory request and `done_o` low. The acknowledge pin is high (the inactive level for polarity 0), and `eot_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle arm pulse; captures control, bases and count |
| cfg_src_hold_i | input | 1 | 1 keeps the source address fixed |
| cfg_dst_hold_i | input | 1 | 1 keeps the destination address fixed |
| cfg_mode_i | input | 2 | 00 software, 01 to device, 10 from device, 11 off |
| cfg_eot_i | input | 2 | End pin: bit 1 selects output, bit 0 the active level |
| cfg_ack_pol_i | input | 1 | Acknowledge active level |
| cfg_req_i | input | 2 | Request: bit 1 selects edge sensing, bit 0 the active level |
| src_base_i | input | AW | Source start address |
| dst_base_i | input | AW | Destination start address |
| word_count_i | input | CW | Words to move |
| busy_o | output | 1 | Channel armed and running |
| done_o | output | 1 | Run ended by count or abort |
| remain_o | output | CW | Words not yet written |
| mem_valid_o | output | 1 | Memory request valid |
| mem_write_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | DW | Read data, valid with an accepted read |
| req_pin_i | input | 1 | External request pin |
| ack_pin_o | output | 1 | External acknowledge pin |
| eot_pin_i | input | 1 | End pin, input side |
| eot_pin_o | output | 1 | End pin, output side |
| eot_oe_o | output | 1 | End pin output enable |

## Verification
On every cycle, the assertions check several properties. The memory request is held steady under back-pressure. The acknowledge and terminal-count pins go active only on an accepted write, and terminal count only on the last word. The remaining count never rises during a run. A finished channel issues no request, and an off-mode start never arms the channel. Some behaviours only the bench's scenarios can show: the exact word timing, the address sequences under each hold setting, and the memory contents after each run. The same holds for pacing by level and by edge in both polarities, and for the count left after an abort arriving at a known cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    XM_SOFT     = 2'b00,
    XM_TO_DEV   = 2'b01,
    XM_FROM_DEV = 2'b10,
    XM_OFF      = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_READ  = 2'b01,
    PH_WRITE = 2'b10
  } phase_e;

  typedef struct packed {
    logic       src_hold;
    logic       dst_hold;
    xfer_mode_e mode;
    logic [1:0] eot_cfg;
    logic       ack_pol;
    logic [1:0] req_cfg;
  } chan_cfg_t;

endpackage

// File: rtl/dma_pin_sync.sv
module dma_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rst_val_i,
  output logic level_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{rst_val_i}};
    else        chain <= {chain[STAGES-2:0], pin_i};
  end

  assign level_o = chain[STAGES-1];
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          hold_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr_o <= '0;
    else if (load_i)           addr_o <= base_i;
    else if (step_i && !hold_i) addr_o <= addr_o + AW'(1);
  end
endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
  import dma_chan_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cfg_src_hold_i,
  input  logic          cfg_dst_hold_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic [1:0]    cfg_eot_i,
  input  logic          cfg_ack_pol_i,
  input  logic [1:0]    cfg_req_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [CW-1:0] word_count_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] remain_o,
  output logic          mem_valid_o,
  output logic          mem_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          req_pin_i,
  output logic          ack_pin_o,
  input  logic          eot_pin_i,
  output logic          eot_pin_o,
  output logic          eot_oe_o
);
  localparam logic [CW-1:0] ONE_WORD = CW'(1);

  chan_cfg_t       cfg_in, cfg_q;
  phase_e          phase_q;
  logic            busy_q, done_q, abort_q, pend_q, req_prev_q;
  logic [CW-1:0]   remain_q;
  logic [DW-1:0]   data_q;
  logic [AW-1:0]   src_addr, dst_addr;
  logic            req_lvl, eot_lvl;

  // control word captured at arm time
  always_comb begin
    cfg_in.src_hold = cfg_src_hold_i;
    cfg_in.dst_hold = cfg_dst_hold_i;
    cfg_in.mode     = xfer_mode_e'(cfg_mode_i);
    cfg_in.eot_cfg  = cfg_eot_i;
    cfg_in.ack_pol  = cfg_ack_pol_i;
    cfg_in.req_cfg  = cfg_req_i;
  end

  logic start_ok;
  assign start_ok = start_i && !busy_q && (xfer_mode_e'(cfg_mode_i) != XM_OFF);

  // pin synchronizers
  dma_pin_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(req_pin_i), .rst_val_i(1'b1), .level_o(req_lvl)
  );
  dma_pin_sync #(.STAGES(SYNC_STAGES)) u_eot_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(eot_pin_i), .rst_val_i(1'b1), .level_o(eot_lvl)
  );

  // request decode
  logic paced, edge_sense, req_act, req_onset;
  assign paced      = (cfg_q.mode == XM_TO_DEV) || (cfg_q.mode == XM_FROM_DEV);
  assign edge_sense = cfg_q.req_cfg[1];
  assign req_act    = (req_lvl == cfg_q.req_cfg[0]);
  assign req_onset  = req_act && (req_prev_q != req_lvl);

  // end pin decode
  logic eot_is_out, eot_act, stop_now;
  assign eot_is_out = cfg_q.eot_cfg[1];
  assign eot_act    = !eot_is_out && (eot_lvl == cfg_q.eot_cfg[0]);
  assign stop_now   = abort_q || eot_act;

  // handshake events
  logic rd_hs, wr_hs, last_word, want_word, take_word;
  assign rd_hs     = (phase_q == PH_READ)  && mem_ready_i;
  assign wr_hs     = (phase_q == PH_WRITE) && mem_ready_i;
  assign last_word = wr_hs && (remain_q == ONE_WORD);
  assign want_word = (cfg_q.mode == XM_SOFT) ||
                     (paced && (edge_sense ? pend_q : req_act));
  assign take_word = want_word && !stop_now && busy_q &&
                     ((phase_q == PH_IDLE) || (wr_hs && !last_word));

  // address generators
  dma_addr_step #(.AW(AW)) u_src_addr (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .base_i(src_base_i),
    .hold_i(cfg_q.src_hold), .step_i(rd_hs), .addr_o(src_addr)
  );
  dma_addr_step #(.AW(AW)) u_dst_addr (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .base_i(dst_base_i),
    .hold_i(cfg_q.dst_hold), .step_i(wr_hs), .addr_o(dst_addr)
  );

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      phase_q    <= PH_IDLE;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      abort_q    <= 1'b0;
      pend_q     <= 1'b0;
      req_prev_q <= 1'b1;
      remain_q   <= '0;
      data_q     <= '0;
    end else begin
      req_prev_q <= req_lvl;
      if (start_ok) begin
        cfg_q    <= cfg_in;
        remain_q <= word_count_i;
        busy_q   <= (word_count_i != '0);
        done_q   <= (word_count_i == '0);
        abort_q  <= 1'b0;
        pend_q   <= 1'b0;
        phase_q  <= PH_IDLE;
      end else begin
        if (busy_q && eot_act) abort_q <= 1'b1;
        pend_q <= (busy_q && paced && edge_sense && req_onset) || (pend_q && !take_word);
        case (phase_q)
          PH_IDLE: begin
            if (busy_q) begin
              if (stop_now) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end else if (want_word) begin
                phase_q <= PH_READ;
              end
            end
          end
          PH_READ: begin
            if (mem_ready_i) begin
              data_q  <= mem_rdata_i;
              phase_q <= PH_WRITE;
            end
          end
          PH_WRITE: begin
            if (mem_ready_i) begin
              remain_q <= remain_q - ONE_WORD;
              if (last_word || stop_now) begin
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                phase_q <= PH_IDLE;
              end else if (want_word) begin
                phase_q <= PH_READ;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  // outputs
  logic ack_evt;
  assign ack_evt     = wr_hs && paced;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign remain_o    = remain_q;
  assign mem_valid_o = (phase_q != PH_IDLE);
  assign mem_write_o = (phase_q == PH_WRITE);
  assign mem_addr_o  = (phase_q == PH_WRITE) ? dst_addr : src_addr;
  assign mem_wdata_o = data_q;
  assign ack_pin_o   = cfg_q.ack_pol ? ack_evt : !ack_evt;
  assign eot_oe_o    = eot_is_out;
  assign eot_pin_o   = eot_is_out ? (cfg_q.eot_cfg[0] ? last_word : !last_word) : 1'b0;
endmodule

// File: rtl/dma_xfer_channel_chk.sv
module dma_xfer_channel_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [1:0]    cfg_mode_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] remain_o,
  input logic          mem_valid_o,
  input logic          mem_write_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic          ack_pin_o,
  input logic          eot_pin_o,
  input logic          eot_oe_o,
  input logic          ack_pol_i,
  input logic          eot_pol_i
);
  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
    $stable(mem_write_o) && $stable(mem_wdata_o));

  assert_ack_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pin_o == ack_pol_i) |-> mem_valid_o && mem_write_o && mem_ready_i);

  assert_tc_last_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eot_oe_o && (eot_pin_o == eot_pol_i) |-> mem_write_o && mem_ready_i && (remain_o == CW'(1)));

  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !mem_valid_o);

  assert_count_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> remain_o <= $past(remain_o));

  assert_mode_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (cfg_mode_i == 2'b11) |=> !busy_o);

  assert_req_needs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> busy_o);
endmodule

bind dma_xfer_channel dma_xfer_channel_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_mode_i(cfg_mode_i),
  .busy_o(busy_o), .done_o(done_o), .remain_o(remain_o),
  .mem_valid_o(mem_valid_o), .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .ack_pin_o(ack_pin_o),
  .eot_pin_o(eot_pin_o), .eot_oe_o(eot_oe_o),
  .ack_pol_i(cfg_q.ack_pol), .eot_pol_i(cfg_q.eot_cfg[0])
);

// File: tb/dma_xfer_channel_bench.sv
`timescale 1ns/1ps
module dma_xfer_channel_bench;
  localparam int AW = 16, DW = 32, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic src_hold = 0, dst_hold = 0, ack_pol = 0;
  logic [1:0] mode = 0, eot_cfg = 0, req_cfg = 0;
  logic [AW-1:0] src_base = 0, dst_base = 0;
  logic [CW-1:0] count = 0;
  logic busy, done, mem_valid, mem_write, ready = 1'b1, ack_pin, req_pin = 1'b0;
  logic eot_in = 1'b1, eot_out, eot_oe;
  logic [CW-1:0] remain;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem [0:63];
  int checks = 0, errors = 0;
  int wr_cnt = 0, ack_cnt = 0, tc_cnt = 0, tc_bad = 0, stall_err = 0;
  logic mon_ack_pol = 0, mon_tc_pol = 0;
  logic prev_stall = 0, prev_write = 0;
  logic [AW-1:0] prev_addr = 0;

  always #2 clk = ~clk;

  dma_xfer_channel #(.AW(AW), .DW(DW), .CW(CW)) u_dma_xfer_channel (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cfg_src_hold_i(src_hold), .cfg_dst_hold_i(dst_hold), .cfg_mode_i(mode),
    .cfg_eot_i(eot_cfg), .cfg_ack_pol_i(ack_pol), .cfg_req_i(req_cfg),
    .src_base_i(src_base), .dst_base_i(dst_base), .word_count_i(count),
    .busy_o(busy), .done_o(done), .remain_o(remain),
    .mem_valid_o(mem_valid), .mem_write_o(mem_write), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(ready), .mem_rdata_i(mem_rdata),
    .req_pin_i(req_pin), .ack_pin_o(ack_pin), .eot_pin_i(eot_in),
    .eot_pin_o(eot_out), .eot_oe_o(eot_oe)
  );

  assign mem_rdata = mem[mem_addr[5:0]];
  always @(posedge clk) if (mem_valid && mem_write && ready) mem[mem_addr[5:0]] <= mem_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_write && ready) wr_cnt++;
      if (ack_pin == mon_ack_pol) ack_cnt++;
      if (eot_oe && eot_out == mon_tc_pol) begin
        tc_cnt++;
        if (remain != 1) tc_bad++;
      end
      if (prev_stall && (!mem_valid || mem_addr != prev_addr || mem_write != prev_write)) stall_err++;
      prev_stall = mem_valid && !ready;
      prev_addr  = mem_addr;
      prev_write = mem_write;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int base, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[base + i] = DW'(seed + i * 7);
  endtask

  task automatic kick(input int sb, input int db, input int n);
    @(posedge clk); #1;
    src_base = AW'(sb); dst_base = AW'(db); count = CW'(n); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wr_cnt = 0; ack_cnt = 0; tc_cnt = 0; tc_bad = 0; stall_err = 0;
  endtask

  task automatic wait_done(output int edges);
    edges = 0;
    while (!done && edges < 400) begin @(posedge clk); #1; edges++; end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !mem_valid, "R11 idle after reset", busy, 0);
    chk(ack_pin == 1'b1, "R11 ack rests high", ack_pin, 1);
    chk(eot_oe == 1'b0, "R11 end pin is input", eot_oe, 0);
  endtask

  task automatic t_soft_run;
    int e;
    src_hold = 0; dst_hold = 0; mode = 2'b00; eot_cfg = 2'b00; mon_ack_pol = 1'b0;
    fill(8, 4, 100);
    kick(8, 32, 4);
    wait_done(e);
    chk(e == 9, "R1 four words in nine edges", e, 9);
    chk(done && !busy && remain == 0, "R4 done at zero", remain, 0);
    for (int i = 0; i < 4; i++) chk(mem[32 + i] == DW'(100 + i * 7), "R3 incrementing dest", mem[32 + i], 100 + i * 7);
    chk(ack_cnt == 0, "R7 no ack in software mode", ack_cnt, 0);
  endtask

  task automatic t_holds;
    int e;
    fill(0, 8, 0);
    mem[5] = 32'h55;
    src_hold = 1; dst_hold = 0;
    kick(5, 40, 3);
    wait_done(e);
    for (int i = 0; i < 3; i++) chk(mem[40 + i] == 32'h55, "R2 fixed source", mem[40 + i], 32'h55);
    fill(16, 3, 300);
    src_hold = 0; dst_hold = 1;
    kick(16, 50, 3);
    wait_done(e);
    chk(mem[50] == DW'(300 + 14), "R3 fixed dest keeps last", mem[50], 314);
    chk(mem[51] != DW'(300 + 14) || mem[51] == 32'h0, "R3 fixed dest neighbour", mem[51], 0);
    chk(wr_cnt == 3, "R3 writes with fixed dest", wr_cnt, 3);
    dst_hold = 0;
  endtask

  task automatic t_zero_and_off;
    kick(0, 60, 0);
    chk(done && !busy, "R4 zero count done at once", done, 1);
    settle(3);
    chk(wr_cnt == 0 && !mem_valid, "R4 zero count no access", wr_cnt, 0);
    mode = 2'b11;
    kick(0, 60, 4);
    settle(3);
    chk(!busy && wr_cnt == 0, "R1 mode 11 stays idle", busy, 0);
    mode = 2'b00;
  endtask

  task automatic t_level;
    int e;
    mode = 2'b01; req_cfg = 2'b01; ack_pol = 1'b1; mon_ack_pol = 1'b1; req_pin = 1'b0;
    settle(4);
    fill(20, 3, 500);
    kick(20, 44, 3);
    settle(10);
    chk(remain == 3 && wr_cnt == 0, "R5 level inactive holds", remain, 3);
    req_pin = 1'b1;
    wait_done(e);
    chk(done && remain == 0, "R5 level active runs", remain, 0);
    chk(ack_cnt == 3, "R7 one active-high ack per word", ack_cnt, 3);
    chk(mem[46] == DW'(514), "R5 level data", mem[46], 514);
    // active-low level, device-to-memory
    mode = 2'b10; req_cfg = 2'b00; ack_pol = 1'b0;
    settle(4);
    kick(20, 56, 2);
    mon_ack_pol = 1'b0; ack_cnt = 0;
    settle(8);
    chk(remain == 2, "R5 active-low idle while high", remain, 2);
    req_pin = 1'b0;
    wait_done(e);
    chk(done && remain == 0, "R5 active-low runs", remain, 0);
    chk(ack_cnt == 2, "R7 one active-low ack per word", ack_cnt, 2);
  endtask

  task automatic t_edge;
    mode = 2'b01; req_cfg = 2'b11; ack_pol = 1'b1; mon_ack_pol = 1'b1; req_pin = 1'b0;
    settle(4);
    kick(20, 8, 3);
    req_pin = 1'b1; settle(6); req_pin = 1'b0; settle(10);
    chk(remain == 2 && wr_cnt == 1, "R6 one word per rising edge", remain, 2);
    req_pin = 1'b1; settle(6); req_pin = 1'b0; settle(10);
    chk(remain == 1, "R6 second edge one more", remain, 1);
    chk(ack_cnt == 2, "R7 ack per edge word", ack_cnt, 2);
    req_pin = 1'b1; settle(12);
    chk(done && remain == 0, "R6 third edge finishes", remain, 0);
    req_pin = 1'b0;
  endtask

  task automatic t_tc;
    int e;
    mode = 2'b00; eot_cfg = 2'b11; mon_tc_pol = 1'b1;
    kick(20, 30, 3);
    wait_done(e);
    chk(tc_cnt == 1 && tc_bad == 0, "R8 single terminal pulse on last word", tc_cnt, 1);
    chk(eot_oe && eot_out == 1'b0, "R8 output rests inactive", eot_out, 0);
    eot_cfg = 2'b10; mon_tc_pol = 1'b0;
    kick(20, 30, 2);
    wait_done(e);
    chk(tc_cnt == 1 && tc_bad == 0, "R8 active-low terminal pulse", tc_cnt, 1);
  endtask

  task automatic t_abort;
    int e;
    mode = 2'b00; eot_cfg = 2'b01; eot_in = 1'b0; mon_tc_pol = 1'bx;
    settle(4);
    kick(0, 0, 20);
    settle(6);
    eot_in = 1'b1;
    wait_done(e);
    chk(done && !busy, "R9 abort ends run", done, 1);
    chk(remain == 16, "R9 count kept after abort", remain, 16);
    chk(wr_cnt == 4, "R9 word in progress finished", wr_cnt, 4);
    eot_cfg = 2'b00;
    settle(4);
  endtask

  task automatic t_stall;
    int e;
    mode = 2'b00; eot_cfg = 2'b00;
    fill(24, 5, 900);
    kick(24, 10, 5);
    e = 0;
    while (!done && e < 200) begin
      ready = (e % 3) != 0;
      @(posedge clk); #1; e++;
    end
    ready = 1'b1;
    chk(done, "R10 run completes under stalls", done, 1);
    chk(stall_err == 0, "R10 request steady while stalled", stall_err, 0);
    for (int i = 0; i < 5; i++) chk(mem[10 + i] == DW'(900 + i * 7), "R10 data under stalls", mem[10 + i], 900 + i * 7);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    settle(3);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_soft_run;
    t_holds;
    t_zero_and_off;
    t_level;
    t_edge;
    t_tc;
    t_abort;
    t_stall;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule